// File: doc/BRIEF.md
# Host and Sequencer Shared Control Flag Register

This block is one control register in a storage bus controller. A host processor and an embedded script sequencer both write it. It holds three live bits: a soft-reset bit, a signal flag and a semaphore. The soft-reset bit drives a hold line, `opRegsHold`. While that line is high, the controller's other operating registers stay at their defaults and its bus outputs are released. The hold line does not pulse the bus reset line.

Either side can raise the signal flag. Reading a separate test register returns the flag and then clears it. If the flag is set while the sequencer is waiting to be selected or reselected, the block sends back a one-cycle early-exit pulse, and the sequencer takes its alternate branch. The semaphore lets the script sequencer and the host pass a mark to each other while scripts run.

The host uses one read/write port. A read is combinational on `hostRdData` and has its side effects at the next clock edge. The sequencer uses a write-only port that targets this register.

Top module: `hsc_flag_reg`

## Requirements
- R1: After the active-low hardware reset `rstN`, control readback is 0, `opRegsHold` is 0 and `earlyExit` is 0.
- R2: A host read of the control address returns soft reset in bit 6, the signal flag in bit 5 and the semaphore in bit 4. Bits 7 and 3..0 always read 0, and writes to those bits have no effect.
- R3: The soft-reset bit changes only on a host write to the control address. It stays set until the host writes it to 0. `opRegsHold` equals it at all times. Its own hold action does not clear it.
- R4: A sequencer write loads bits 5 and 4 from `seqWrData[5:4]` and leaves the soft-reset bit unchanged.
- R5: When the host writes the control address and the sequencer writes in the same cycle, bits 5 and 4 take the host's value.
- R6: A host read of the test address returns the signal flag in bit 0, with all other bits 0. The flag is clear after that clock edge.
- R7: If the sequencer writes the flag to 1 in the same cycle that the host reads the test address, the read returns the old flag and the flag is set afterwards.
- R8: `earlyExit` goes high for exactly one cycle, in the cycle after the first cycle in which the flag and `waitActive` are both high. It stays low while both remain high.
- R9: `earlyExit` stays low when `waitActive` was low in the previous cycle.
- R10: A host write to the test address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W | Host register address |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Host read data, combinational |
| seqWrEn | input | 1 | Sequencer write strobe |
| seqWrData | input | DATA_W | Sequencer write data |
| waitActive | input | 1 | Sequencer is waiting for selection or reselection |
| earlyExit | output | 1 | One-cycle abort pulse to the sequencer |
| opRegsHold | output | 1 | Holds other operating registers at their defaults |

## Verification
The hardest state to reach is a collision on the signal flag. One case is the host reading the test address while the sequencer sets the flag. The other is host and sequencer writes landing in the same cycle while `waitActive` is toggling, so that a pulse edge meets a clear. Directed steps create each collision once. A seeded random phase then drives both ports and the wait input on every cycle with independent probabilities, and covers those overlaps many times against a cycle-level reference model.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef struct packed {
    logic ctrlWr;   // host writes control address
    logic testWr;   // host writes test address (ignored)
    logic testRd;   // host reads test address (clears flag)
    logic seqWr;    // sequencer write
  } hscStrobe_t;

  localparam int unsigned BIT_SRST = 6;
  localparam int unsigned BIT_SIG  = 5;
  localparam int unsigned BIT_SEM  = 4;
endpackage

// File: rtl/hsc_ctrl.sv
module hsc_ctrl #(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 9
) (
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              seqWrEn,
  output hsc_pkg::hscStrobe_t strb,
  output logic              rdSelCtrl,
  output logic              rdSelTest
);
  logic hitCtrl, hitTest;

  always_comb begin
    hitCtrl     = (hostAddr == CTRL_ADDR);
    hitTest     = (hostAddr == TEST_ADDR);
    strb.ctrlWr = hostWrEn & hitCtrl;
    strb.testWr = hostWrEn & hitTest;
    strb.testRd = hostRdEn & hitTest;
    strb.seqWr  = seqWrEn;
    rdSelCtrl   = hostRdEn & hitCtrl;
    rdSelTest   = hostRdEn & hitTest;
  end
endmodule

// File: rtl/hsc_dp.sv
module hsc_dp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  hsc_pkg::hscStrobe_t strb,
  input  logic                rdSelCtrl,
  input  logic                rdSelTest,
  input  logic [DATA_W-1:0]   hostWrData,
  input  logic [DATA_W-1:0]   seqWrData,
  input  logic                waitActive,
  output logic [DATA_W-1:0]   hostRdData,
  output logic                earlyExit,
  output logic                softRst,
  output logic                sigFlag,
  output logic                semBit
);
  import hsc_pkg::*;

  logic sigNext, semNext, rstNext;
  logic abortCond, abortCondQ;
  wire  unusedTestWr = strb.testWr;

  always_comb begin
    rstNext = softRst;
    sigNext = sigFlag;
    semNext = semBit;
    if (strb.testRd) sigNext = 1'b0;
    if (strb.seqWr) begin
      sigNext = seqWrData[BIT_SIG];
      semNext = seqWrData[BIT_SEM];
    end
    if (strb.ctrlWr) begin
      rstNext = hostWrData[BIT_SRST];
      sigNext = hostWrData[BIT_SIG];
      semNext = hostWrData[BIT_SEM];
    end
  end

  assign abortCond = sigFlag & waitActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRst    <= 1'b0;
      sigFlag    <= 1'b0;
      semBit     <= 1'b0;
      abortCondQ <= 1'b0;
      earlyExit  <= 1'b0;
    end else begin
      softRst    <= rstNext;
      sigFlag    <= sigNext;
      semBit     <= semNext;
      abortCondQ <= abortCond;
      earlyExit  <= abortCond & ~abortCondQ;
    end
  end

  always_comb begin
    hostRdData = '0;
    if (rdSelCtrl) begin
      hostRdData[BIT_SRST] = softRst;
      hostRdData[BIT_SIG]  = sigFlag;
      hostRdData[BIT_SEM]  = semBit;
    end else if (rdSelTest) begin
      hostRdData[0] = sigFlag;
    end
  end
endmodule

// File: rtl/hsc_flag_reg.sv
module hsc_flag_reg #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              seqWrEn,
  input  logic [DATA_W-1:0] seqWrData,
  input  logic              waitActive,
  output logic              earlyExit,
  output logic              opRegsHold
);
  hsc_pkg::hscStrobe_t strb;
  logic rdSelCtrl, rdSelTest;
  logic softRst, sigFlag, semBit;
  wire  unusedSem = semBit;

  hsc_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .TEST_ADDR(TEST_ADDR)) u_ctrl (
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .seqWrEn(seqWrEn), .strb(strb), .rdSelCtrl(rdSelCtrl), .rdSelTest(rdSelTest)
  );

  hsc_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSelCtrl(rdSelCtrl), .rdSelTest(rdSelTest),
    .hostWrData(hostWrData), .seqWrData(seqWrData), .waitActive(waitActive),
    .hostRdData(hostRdData), .earlyExit(earlyExit), .softRst(softRst),
    .sigFlag(sigFlag), .semBit(semBit)
  );

  assign opRegsHold = softRst;
endmodule

// File: rtl/hsc_flag_reg_sva.sv
module hsc_flag_reg_sva #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic              hostRdEn,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] hostWrData,
  input logic [DATA_W-1:0] hostRdData,
  input logic              seqWrEn,
  input logic [DATA_W-1:0] seqWrData,
  input logic              waitActive,
  input logic              earlyExit,
  input logic              opRegsHold,
  input logic              sigFlag
);
  wire hCtrlWr = hostWrEn && hostAddr == CTRL_ADDR;
  wire hCtrlRd = hostRdEn && hostAddr == CTRL_ADDR;
  wire hTestRd = hostRdEn && hostAddr == TEST_ADDR;
  wire unusedWd = ^hostWrData;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !hCtrlWr |=> $stable(opRegsHold)); // R3
  AST_HOLD_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    hCtrlRd |-> hostRdData[6] == opRegsHold); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    hCtrlRd |-> (hostRdData[7] == 1'b0 && hostRdData[3:0] == 4'd0)); // R2
  AST_TEST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (hTestRd && !seqWrEn) |=> !sigFlag); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (hTestRd && seqWrEn && seqWrData[5]) |=> sigFlag); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    earlyExit |=> !earlyExit); // R8
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !waitActive |=> !earlyExit); // R9
endmodule

bind hsc_flag_reg hsc_flag_reg_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .TEST_ADDR(TEST_ADDR)
) u_sva (.*);

// File: tb/hsc_flag_reg_tb.sv
`timescale 1ns/1ps
module hsc_flag_reg_tb;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] CA = 2;
  localparam logic [AW-1:0] TA = 9;

  logic clk = 0, rstN = 0;
  logic hostWrEn = 0, hostRdEn = 0, seqWrEn = 0, waitActive = 0;
  logic [AW-1:0] hostAddr = 0;
  logic [DW-1:0] hostWrData = 0, seqWrData = 0, hostRdData;
  logic earlyExit, opRegsHold;
  int nChk = 0, nBad = 0;
  bit mRst, mSig, mSem, mCondQ, mPulse;

  always #5 clk = ~clk;

  hsc_flag_reg #(.ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR(CA), .TEST_ADDR(TA)) u_dut (.*);

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ctrlView();
    return {1'b0, mRst, mSig, mSem, 4'h0};
  endfunction

  // op: 0 idle, 1 write ctrl, 2 read ctrl, 3 read test, 4 write test
  task automatic step(int op, logic [DW-1:0] hd, bit sEn, logic [DW-1:0] sd, bit w, string tag);
    bit cond;
    @(negedge clk);
    hostWrEn = (op == 1 || op == 4);
    hostRdEn = (op == 2 || op == 3);
    hostAddr = (op == 3 || op == 4) ? TA : CA;
    hostWrData = hd; seqWrEn = sEn; seqWrData = sd; waitActive = w;
    #1;
    if (op == 2) chk({tag, " ctrl read"}, hostRdData, ctrlView());
    if (op == 3) chk({tag, " test read"}, hostRdData, {7'd0, mSig});
    @(posedge clk);
    cond = mSig & w;
    mPulse = cond & ~mCondQ;
    mCondQ = cond;
    if (op == 3) mSig = 0;
    if (sEn) begin mSig = sd[5]; mSem = sd[4]; end
    if (op == 1) begin mRst = hd[6]; mSig = hd[5]; mSem = hd[4]; end
    #1;
    chk({tag, " earlyExit"}, {7'd0, earlyExit}, {7'd0, mPulse});
    chk({tag, " opRegsHold"}, {7'd0, opRegsHold}, {7'd0, mRst});
  endtask

  task automatic hwReset();
    @(negedge clk);
    rstN = 0; hostWrEn = 0; hostRdEn = 0; seqWrEn = 0; waitActive = 0;
    @(negedge clk);
    rstN = 1;
    mRst = 0; mSig = 0; mSem = 0; mCondQ = 0; mPulse = 0;
  endtask

  initial begin
    #1_000_000;
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    hwReset();
    #1;
    chk("R1 earlyExit", {7'd0, earlyExit}, 8'd0);
    chk("R1 hold", {7'd0, opRegsHold}, 8'd0);
    step(2, 0, 0, 0, 0, "R1");
    step(1, 8'hFF, 0, 0, 0, "R2");
    step(2, 0, 0, 0, 0, "R2");
    step(1, 8'h40, 0, 0, 0, "R3");
    step(0, 0, 1, 8'h00, 0, "R4");
    step(0, 0, 0, 0, 0, "R3");
    step(2, 0, 0, 0, 0, "R3");
    step(1, 8'h00, 0, 0, 0, "R3");
    step(4, 8'hFF, 0, 0, 0, "R10");
    step(2, 0, 0, 0, 0, "R10");
    step(3, 0, 0, 0, 0, "R10");
    step(0, 0, 1, 8'h30, 0, "R4");
    step(2, 0, 0, 0, 0, "R4");
    step(3, 0, 0, 0, 0, "R6");
    step(3, 0, 0, 0, 0, "R6");
    step(2, 0, 0, 0, 0, "R6");
    step(1, 8'h00, 1, 8'h30, 0, "R5");
    step(2, 0, 0, 0, 0, "R5");
    step(3, 0, 1, 8'h20, 0, "R7");
    step(2, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 1, "R8");
    step(1, 8'h50, 0, 0, 1, "R1");
    hwReset();
    step(2, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 3000; i++) begin
      int r;
      int op;
      r = $urandom_range(0, 9);
      op = (r < 4) ? 0 : (r < 6) ? 1 : (r < 8) ? 2 : (r < 9) ? 3 : 4;
      step(op, 8'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom),
           ($urandom_range(0, 2) != 0), "R5 R7 R8 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule